// File: doc/BRIEF.md
# AC97 Codec Register Access Engine

This block is the controller-side command engine of an AC97 link. A CPU-facing request port asks for one codec register access at a time. A write carries a 7-bit register index and 16 bits of data. A read carries only the index. The engine turns the accepted request into the command-address slot and the command-data slot of the next outgoing frame. It flags those two slots valid for that one frame only.

On the receive side the block works on parallel 20-bit slot words. Each word comes with its slot index, and the slot-0 tag word arrives first. A frame has 13 slot positions, so the slot-count code is 12, and each audio word is 16 bits wide. The engine checks that the returned status address belongs to the outstanding read before it takes the register value from the status-data slot. It raises its update flag only when that value differs from the one it already holds. Every tagged slot from 3 to 12 goes into one merged 16-bit receive stream, in arrival order. This includes slot 12, which carries codec GPIO status, so that data appears among the PCM samples.

Bit-level serialisation, codec reset sequencing and the analog codec are handled elsewhere.

Top module: `ac97_reg_engine`

## Requirements
- R1: When `busy` is low, a `wr_stb` or `rd_stb` is accepted and `busy` reads high from the next cycle. If both strobes are high together, the request is a write.
- R2: A strobe that arrives while `busy` is high is ignored. Its address and data never appear in any outgoing frame.
- R3: An accepted command goes into the first frame whose `frame_start` comes after the accepting edge. The command slots and their valid flags change only at `frame_start`. The valid flags are high for exactly that one frame, and `busy` falls at the same edge.
- R4: The command-address word has bit 19 = 1 for a read and 0 for a write, the register index in bits 18:12, and zero in bits 11:0. In a frame that carries no command, both command words are zero.
- R5: For a write, the command-data word is the write data in bits 19:4 with bits 3:0 zero, and `tx_data_vld` is high. For a read, the command-data word is zero and `tx_data_vld` is low.
- R6: The slot-0 word of a receive frame is the tag. Bit 19 marks the frame valid, and bit 19−i marks slot i valid for i from 1 to 12. A slot is used only when both bits are set. Slot indices above 12 are never used.
- R7: A returned value is taken only while a read has been sent and not yet answered, and only when slot 1 of the same frame carried bits 18:12 equal to the requested index. If the index does not match, `rd_data` keeps its value.
- R8: The captured value is bits 19:4 of slot 2. `rd_updated` is set only when this value differs from the held `rd_data`. It is cleared when the next request is accepted.
- R9: Each used slot from 3 to 12 produces one `rx_out_valid` pulse in the cycle after its word, with `rx_out_data` equal to bits 19:4 of that word. The pulses come in slot order, and no slot can be singled out.
- R10: After reset, `busy`, both valid flags, both command words, `rd_data`, `rd_updated` and `rx_out_valid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_addr | input | 7 | Codec register index of a request |
| req_wdata | input | 16 | Write data of a request |
| wr_stb | input | 1 | Write request strobe |
| rd_stb | input | 1 | Read request strobe |
| busy | output | 1 | A command is waiting for its frame |
| rd_data | output | 16 | Last captured register value |
| rd_updated | output | 1 | Last capture changed `rd_data` |
| frame_start | input | 1 | Start of a new outgoing frame |
| tx_addr_word | output | 20 | Outgoing command-address slot |
| tx_data_word | output | 20 | Outgoing command-data slot |
| tx_addr_vld | output | 1 | Tag bit for the command-address slot |
| tx_data_vld | output | 1 | Tag bit for the command-data slot |
| rx_valid | input | 1 | A received slot word is present |
| rx_slot | input | 4 | Index of the received slot |
| rx_word | input | 20 | Received slot word |
| rx_out_valid | output | 1 | Merged receive stream sample valid |
| rx_out_data | output | 16 | Merged receive stream sample |

## Verification
The bench issues a strobe in the same cycle as `frame_start`. A design that sent the command at once would put it one frame too early. The bench sends strobes while `busy` is high, and a design that accepted them would overwrite the pending command. It re-reads a register whose value has not changed, where a wrong design would raise `rd_updated` anyway. It returns a status frame with the wrong address, and one whose frame-valid bit is clear, where a wrong design would corrupt `rd_data` or emit stream samples. A long random phase, checked cycle by cycle against a behavioural model, covers captures that land on the same edge as new commands.

// File: rtl/ac97_eng_pkg.sv
// Package: slot-field positions and the command direction type shared by
// the register access engine. Assumes 20-bit slot words.
package ac97_eng_pkg;
    localparam int RW_BIT     = 19;  // read/write flag in command address
    localparam int ADDR_LSB   = 12;  // register index start in address slot
    localparam int DATA_LSB   = 4;   // 16-bit value start in data slots
    localparam int SLOT_STAT_ADDR = 1;
    localparam int SLOT_STAT_DATA = 2;
    localparam int SLOT_FIRST_PCM = 3;

    typedef enum logic {
        CMD_WRITE = 1'b0,
        CMD_READ  = 1'b1
    } cmd_dir_e;
endpackage

// File: rtl/ac97_cmd_issue.sv
// Command issue: accepts one CPU request while idle and places it into the
// command slots on the next frame start. Assumes frame_start is a
// single-cycle strobe and that slots hold steady for a whole frame.
module ac97_cmd_issue
    import ac97_eng_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16,
    parameter int SLOT_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              frame_start,
    output logic              busy,
    output logic              accept,
    output logic              issue_rd,
    output logic [ADDR_W-1:0] issue_addr,
    output logic [SLOT_W-1:0] tx_addr_word,
    output logic [SLOT_W-1:0] tx_data_word,
    output logic              tx_addr_vld,
    output logic              tx_data_vld
);
    logic              busy_q;
    cmd_dir_e          dir_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [SLOT_W-1:0] addr_word_nx;
    logic [SLOT_W-1:0] data_word_nx;

    assign accept     = !busy_q && (wr_stb || rd_stb);
    assign issue_rd   = frame_start && busy_q && (dir_q == CMD_READ);
    assign issue_addr = addr_q;
    assign busy       = busy_q;

    // Build the slot words for the pending command.
    always_comb begin
        addr_word_nx = (SLOT_W'(addr_q) << ADDR_LSB);
        addr_word_nx[RW_BIT] = (dir_q == CMD_READ);
        data_word_nx = (dir_q == CMD_READ) ? '0 : (SLOT_W'(data_q) << DATA_LSB);
    end

    // Hold the request and drive the command slots frame by frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q       <= 1'b0;
            dir_q        <= CMD_WRITE;
            addr_q       <= '0;
            data_q       <= '0;
            tx_addr_word <= '0;
            tx_data_word <= '0;
            tx_addr_vld  <= 1'b0;
            tx_data_vld  <= 1'b0;
        end else begin
            if (accept) begin
                busy_q <= 1'b1;
                dir_q  <= wr_stb ? CMD_WRITE : CMD_READ;
                addr_q <= req_addr;
                data_q <= req_wdata;
            end
            if (frame_start) begin
                if (busy_q) begin
                    busy_q       <= 1'b0;
                    tx_addr_word <= addr_word_nx;
                    tx_data_word <= data_word_nx;
                    tx_addr_vld  <= 1'b1;
                    tx_data_vld  <= (dir_q == CMD_WRITE);
                end else begin
                    tx_addr_word <= '0;
                    tx_data_word <= '0;
                    tx_addr_vld  <= 1'b0;
                    tx_data_vld  <= 1'b0;
                end
            end
        end
    end

    a_r3_busy_clears: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && frame_start |=> !busy_q);
    a_r2_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && !frame_start |=> busy_q && $stable(addr_q) && $stable(data_q));
    a_r3_tag_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(tx_addr_vld) && $stable(tx_addr_word));
    a_r5_data_tag_write: assert property (@(posedge clk) disable iff (!rst_n)
        tx_data_vld |-> tx_addr_vld && !tx_addr_word[RW_BIT]);
endmodule

// File: rtl/ac97_rx_merge.sv
// Receive merge: latches the slot-0 tag, decodes which slots are usable,
// and forwards every usable slot from 3 upward into one sample stream.
// Assumes slot words arrive in slot order, slot 0 first.
module ac97_rx_merge
    import ac97_eng_pkg::*;
#(
    parameter int NUM_SLOTS  = 13,
    parameter int SLOT_W     = 20,
    parameter int DATA_W     = 16,
    parameter int SLOT_IDX_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_valid,
    input  logic [SLOT_IDX_W-1:0] rx_slot,
    input  logic [SLOT_W-1:0]     rx_word,
    output logic                  slot_ok,
    output logic                  rx_out_valid,
    output logic [DATA_W-1:0]     rx_out_data
);
    localparam int IDX_SPAN = 2 ** SLOT_IDX_W;

    logic [SLOT_W-1:0]   tag_q;
    logic [IDX_SPAN-1:0] slot_en;

    // Per-slot usable flag from the tag: frame bit and the slot's own bit.
    for (genvar i = 0; i < IDX_SPAN; i++) begin : g_slot_en
        if (i >= 1 && i < NUM_SLOTS) begin : g_used
            assign slot_en[i] = tag_q[SLOT_W-1] && tag_q[SLOT_W-1-i];
        end else begin : g_unused
            assign slot_en[i] = 1'b0;
        end
    end

    assign slot_ok = rx_valid && slot_en[rx_slot];

    // Latch the tag and emit merged stream samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q        <= '0;
            rx_out_valid <= 1'b0;
            rx_out_data  <= '0;
        end else begin
            rx_out_valid <= 1'b0;
            if (rx_valid && rx_slot == '0) begin
                tag_q <= rx_word;
            end
            if (slot_ok && rx_slot >= SLOT_IDX_W'(SLOT_FIRST_PCM)) begin
                rx_out_valid <= 1'b1;
                rx_out_data  <= rx_word[DATA_LSB +: DATA_W];
            end
        end
    end

    a_r9_stream_source: assert property (@(posedge clk) disable iff (!rst_n)
        rx_out_valid |-> $past(rx_valid) && ($past(rx_slot) >= SLOT_IDX_W'(SLOT_FIRST_PCM)));
    a_r6_no_high_slot: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && (rx_slot >= SLOT_IDX_W'(NUM_SLOTS)) |-> !slot_ok);
endmodule

// File: rtl/ac97_status_capture.sv
// Status capture: tracks the outstanding read, checks the returned status
// address and keeps the register value with a change-only update flag.
// Assumes slot 1 of a frame arrives before slot 2.
module ac97_status_capture
    import ac97_eng_pkg::*;
#(
    parameter int ADDR_W     = 7,
    parameter int DATA_W     = 16,
    parameter int SLOT_W     = 20,
    parameter int SLOT_IDX_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_valid,
    input  logic [SLOT_IDX_W-1:0] rx_slot,
    input  logic [SLOT_W-1:0]     rx_word,
    input  logic                  slot_ok,
    input  logic                  accept,
    input  logic                  issue_rd,
    input  logic [ADDR_W-1:0]     issue_addr,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  rd_updated
);
    logic              wait_q;
    logic              match_q;
    logic [ADDR_W-1:0] want_q;
    logic [DATA_W-1:0] new_val;

    assign new_val = rx_word[DATA_LSB +: DATA_W];

    // Follow the read from issue to its answer and hold the value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q     <= 1'b0;
            match_q    <= 1'b0;
            want_q     <= '0;
            rd_data    <= '0;
            rd_updated <= 1'b0;
        end else begin
            if (accept) begin
                rd_updated <= 1'b0;
            end
            if (rx_valid && rx_slot == '0) begin
                match_q <= 1'b0;
            end
            if (slot_ok && rx_slot == SLOT_IDX_W'(SLOT_STAT_ADDR)) begin
                match_q <= (rx_word[ADDR_LSB +: ADDR_W] == want_q);
            end
            if (slot_ok && rx_slot == SLOT_IDX_W'(SLOT_STAT_DATA) && match_q && wait_q) begin
                wait_q <= 1'b0;
                if (new_val != rd_data) begin
                    rd_data    <= new_val;
                    rd_updated <= 1'b1;
                end
            end
            if (issue_rd) begin
                wait_q <= 1'b1;
                want_q <= issue_addr;
            end
        end
    end

    a_r8_update_changes: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_updated) |-> rd_data != $past(rd_data));
    a_r7_rd_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(slot_ok && rx_slot == SLOT_IDX_W'(SLOT_STAT_DATA)) |=> $stable(rd_data));
    a_r8_clear_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !(slot_ok && rx_slot == SLOT_IDX_W'(SLOT_STAT_DATA)) |=> !rd_updated);
endmodule

// File: rtl/ac97_reg_engine.sv
// Top: AC97 codec register access engine. Joins command issue, status
// capture and the merged receive stream. Assumes parallel slot words with
// a frame strobe; no bit-level serialisation here.
module ac97_reg_engine #(
    parameter int ADDR_W    = 7,
    parameter int DATA_W    = 16,
    parameter int SLOT_W    = 20,
    parameter int NUM_SLOTS = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              wr_stb,
    input  logic              rd_stb,
    output logic              busy,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_updated,
    input  logic              frame_start,
    output logic [SLOT_W-1:0] tx_addr_word,
    output logic [SLOT_W-1:0] tx_data_word,
    output logic              tx_addr_vld,
    output logic              tx_data_vld,
    input  logic              rx_valid,
    input  logic [3:0]        rx_slot,
    input  logic [SLOT_W-1:0] rx_word,
    output logic              rx_out_valid,
    output logic [DATA_W-1:0] rx_out_data
);
    localparam int SLOT_IDX_W    = $clog2(NUM_SLOTS);
    localparam int SLOT_CNT_CODE = NUM_SLOTS - 1;

    logic              accept;
    logic              issue_rd;
    logic [ADDR_W-1:0] issue_addr;
    logic              slot_ok;

    initial begin
        assert (SLOT_IDX_W == 4 && SLOT_CNT_CODE == 12)
            else $error("frame layout must be 13 slots");
    end

    ac97_cmd_issue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_issue (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .req_addr(req_addr), .req_wdata(req_wdata), .frame_start(frame_start),
        .busy(busy), .accept(accept), .issue_rd(issue_rd), .issue_addr(issue_addr),
        .tx_addr_word(tx_addr_word), .tx_data_word(tx_data_word),
        .tx_addr_vld(tx_addr_vld), .tx_data_vld(tx_data_vld)
    );

    ac97_rx_merge #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .DATA_W(DATA_W),
                    .SLOT_IDX_W(SLOT_IDX_W)) u_merge (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_slot(rx_slot),
        .rx_word(rx_word), .slot_ok(slot_ok), .rx_out_valid(rx_out_valid),
        .rx_out_data(rx_out_data)
    );

    ac97_status_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_W(SLOT_W),
                          .SLOT_IDX_W(SLOT_IDX_W)) u_capture (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_slot(rx_slot),
        .rx_word(rx_word), .slot_ok(slot_ok), .accept(accept),
        .issue_rd(issue_rd), .issue_addr(issue_addr),
        .rd_data(rd_data), .rd_updated(rd_updated)
    );
endmodule

// File: tb/ac97_reg_engine_bench.sv
// Bench: behavioural reference model compared on every clock, plus directed
// checks on the frame timing, formats and capture corner cases.
module ac97_reg_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        wr_stb = 1'b0, rd_stb = 1'b0, frame_start = 1'b0;
    logic        rx_valid = 1'b0;
    logic [3:0]  rx_slot = '0;
    logic [19:0] rx_word = '0;
    logic        busy, rd_updated, tx_addr_vld, tx_data_vld, rx_out_valid;
    logic [15:0] rd_data, rx_out_data;
    logic [19:0] tx_addr_word, tx_data_word;

    int errors = 0, checks = 0, cycles = 0, pulses = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ac97_reg_engine u_ac97_reg_engine (
        .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_wdata(req_wdata),
        .wr_stb(wr_stb), .rd_stb(rd_stb), .busy(busy), .rd_data(rd_data),
        .rd_updated(rd_updated), .frame_start(frame_start),
        .tx_addr_word(tx_addr_word), .tx_data_word(tx_data_word),
        .tx_addr_vld(tx_addr_vld), .tx_data_vld(tx_data_vld),
        .rx_valid(rx_valid), .rx_slot(rx_slot), .rx_word(rx_word),
        .rx_out_valid(rx_out_valid), .rx_out_data(rx_out_data)
    );

    // Reference model state.
    bit        m_busy, m_dir, m_av, m_dv, m_wait, m_match, m_upd, m_ov;
    bit [6:0]  m_addr, m_want;
    bit [15:0] m_data, m_held, m_od;
    bit [19:0] m_s1, m_s2, m_tag;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Model update at each rising edge from the inputs held there.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_busy = 0; m_dir = 0; m_av = 0; m_dv = 0; m_wait = 0; m_match = 0;
            m_upd = 0; m_ov = 0; m_addr = 0; m_want = 0; m_data = 0; m_held = 0;
            m_od = 0; m_s1 = 0; m_s2 = 0; m_tag = 0;
        end else begin
            bit ob, ow, om, acc, iss, ok;
            bit [6:0]  owant;
            bit [19:0] otag;
            ob = m_busy; ow = m_wait; om = m_match; owant = m_want; otag = m_tag;
            iss = 0;
            if (frame_start) begin
                if (ob) begin
                    m_s1 = {m_dir, m_addr, 12'h000};
                    m_s2 = m_dir ? 20'h0 : {m_data, 4'h0};
                    m_av = 1; m_dv = !m_dir; iss = m_dir; m_busy = 0;
                end else begin
                    m_s1 = 0; m_s2 = 0; m_av = 0; m_dv = 0;
                end
            end
            acc = !ob && (wr_stb || rd_stb);
            if (acc) begin
                m_busy = 1; m_dir = !wr_stb; m_addr = req_addr; m_data = req_wdata;
                m_upd = 0;
            end
            ok = rx_valid && rx_slot >= 1 && rx_slot <= 12 && otag[19] && otag[19 - rx_slot];
            m_ov = ok && rx_slot >= 3;
            if (m_ov) m_od = rx_word[19:4];
            if (rx_valid && rx_slot == 0) begin m_tag = rx_word; m_match = 0; end
            if (ok && rx_slot == 1) m_match = (rx_word[18:12] == owant);
            if (ok && rx_slot == 2 && om && ow) begin
                m_wait = 0;
                if (rx_word[19:4] != m_held) begin m_held = rx_word[19:4]; m_upd = 1; end
            end
            if (iss) begin m_wait = 1; m_want = m_addr; end
        end
    end

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R1 busy", busy, m_busy);
            check("R4 tx_addr_word", tx_addr_word, m_s1);
            check("R5 tx_data_word", tx_data_word, m_s2);
            check("R3 tx_addr_vld", tx_addr_vld, m_av);
            check("R5 tx_data_vld", tx_data_vld, m_dv);
            check("R7 rd_data", rd_data, m_held);
            check("R8 rd_updated", rd_updated, m_upd);
            check("R9 rx_out_valid", rx_out_valid, m_ov);
            if (m_ov) check("R9 rx_out_data", rx_out_data, m_od);
        end
        if (rst_n && rx_out_valid) pulses++;
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        if (cycles > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
            finish_run();
        end
    end

    task automatic step();
        @(posedge clk); #1;
        wr_stb = 0; rd_stb = 0; frame_start = 0; rx_valid = 0;
    endtask

    task automatic rx_frame(input logic [19:0] tag, input logic [19:0] s1,
                            input logic [19:0] s2, input bit extra);
        for (int i = 0; i < 13; i++) begin
            step();
            rx_valid = 1; rx_slot = 4'(i);
            rx_word = (i == 0) ? tag : (i == 1) ? s1 : (i == 2) ? s2 : 20'((i * 16) + 20'h11110);
        end
        if (extra) begin step(); rx_valid = 1; rx_slot = 4'd13; rx_word = 20'hFFFF0; end
        step(); step();
    endtask

    task automatic issue_frame();
        step(); frame_start = 1; step();
    endtask

    initial begin
        step(); step();
        // R10: reset state
        check("R10 busy", busy, 0);
        check("R10 tx_addr_vld", tx_addr_vld, 0);
        check("R10 tx_addr_word", tx_addr_word, 0);
        check("R10 rd_data", rd_data, 0);
        check("R10 rd_updated", rd_updated, 0);
        check("R10 rx_out_valid", rx_out_valid, 0);
        rst_n = 1;
        step();
        // Write request, then an ignored read while busy.
        req_addr = 7'h2A; req_wdata = 16'hBEEF; wr_stb = 1;
        step();
        check("R1 busy after write", busy, 1);
        req_addr = 7'h11; rd_stb = 1;
        issue_frame();
        check("R4 write address word", tx_addr_word, 20'h2A000);
        check("R5 write data word", tx_data_word, 20'hBEEF0);
        check("R5 write data tag", tx_data_vld, 1);
        check("R3 busy falls at frame", busy, 0);
        issue_frame();
        check("R3 tag one frame", tx_addr_vld, 0);
        check("R2 ignored read not sent", tx_addr_word, 0);
        // Read strobe in the same cycle as a frame start.
        step(); req_addr = 7'h1C; rd_stb = 1; frame_start = 1;
        step();
        check("R3 not in current frame", tx_addr_vld, 0);
        frame_start = 1; step();
        check("R4 read address word", tx_addr_word, 20'h9C000);
        check("R5 read data tag low", tx_data_vld, 0);
        check("R5 read data word zero", tx_data_word, 0);
        rx_frame(20'hE0000, 20'h1C000, 20'h12340, 0);
        check("R8 first value", rd_data, 16'h1234);
        check("R8 flag set", rd_updated, 1);
        // Re-read the same unchanged register.
        step(); req_addr = 7'h1C; rd_stb = 1;
        issue_frame();
        rx_frame(20'hE0000, 20'h1C000, 20'h12340, 0);
        check("R8 unchanged value no flag", rd_updated, 0);
        // Mismatched status address.
        step(); req_addr = 7'h05; rd_stb = 1;
        issue_frame();
        rx_frame(20'hE0000, 20'h06000, 20'hABCD0, 0);
        check("R7 mismatch holds", rd_data, 16'h1234);
        // Frame-valid bit clear: nothing is used.
        pulses = 0;
        rx_frame(20'h7FFF0, 20'h05000, 20'hABCD0, 0);
        check("R6 invalid frame holds rd_data", rd_data, 16'h1234);
        check("R6 invalid frame no stream", pulses, 0);
        rx_frame(20'hE0000, 20'h05000, 20'hABCD0, 0);
        check("R7 matching answer taken", rd_data, 16'hABCD);
        // Stream: slots 3, 4 and 12 tagged, slot 13 presented.
        pulses = 0;
        rx_frame(20'h98080, 20'h0, 20'h0, 1);
        check("R9 three stream samples", pulses, 3);
        // Both strobes together: write wins.
        step(); req_addr = 7'h33; req_wdata = 16'h0F0F; wr_stb = 1; rd_stb = 1;
        issue_frame();
        check("R1 write priority", tx_addr_word, 20'h33000);
        check("R1 write priority data", tx_data_word, 20'h0F0F0);
        // Random phase against the model.
        for (int n = 0; n < 4000; n++) begin
            step();
            wr_stb = ($urandom_range(0, 7) == 0);
            rd_stb = ($urandom_range(0, 5) == 0);
            frame_start = ($urandom_range(0, 9) == 0);
            req_addr = 7'($urandom_range(0, 3));
            req_wdata = 16'($urandom);
            rx_valid = $urandom_range(0, 1) == 1;
            rx_slot = 4'($urandom_range(0, 15));
            rx_word = 20'($urandom);
            if (rx_slot == 1) rx_word[18:12] = 7'($urandom_range(0, 3));
            if (rx_slot == 0) rx_word[19] = ($urandom_range(0, 3) != 0);
        end
        step(); step();
        finish_run();
    end
endmodule